// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the software-visible register front end of a 24-input interrupt router. Software reaches the router's internal registers indirectly. It first writes an 8-bit index into a select register. It then reads or writes a 32-bit data window, and that access lands on the register the index names. Behind the window sit these registers:
- an identification register;
- a read-only version register;
- an arbitration register that mirrors the identification value;
- one 64-bit routing entry per input, reached as two 32-bit halves.

A separate end-of-interrupt register exists only when the block is built as version 0x20. A write to it emits the written vector on a one-cycle broadcast strobe.

The routing table is exported as a flat bus to the delivery logic, which sits outside this block. That logic reports two status bits per entry back through set and clear pulses: delivery status and remote request. Software writes never alter these two bits. The one exception is an entry written as edge-triggered, whose remote-request bit is forced to zero. Every accepted entry write raises a one-cycle "entry changed" pulse carrying the entry index, so the delivery logic can re-evaluate pending requests.

Accesses are handled by a four-state machine:
- ST_IDLE accepts an access. A read moves it to ST_READ. An entry write moves it to ST_ENTRY. An enabled end-of-interrupt write moves it to ST_EOI. Any other write leaves it in ST_IDLE.
- ST_READ presents the read data for one cycle.
- ST_ENTRY raises the entry-changed pulse.
- ST_EOI raises the broadcast strobe.

Each of the three response states returns to ST_IDLE after one cycle. The VERSION parameter may only be 0x11 or 0x20; 0x20 is the default.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, the select index and identification are zero. Every entry holds only its mask bit (bit 16). acc_ready is high, and no pulse output is active.
- R2: Only acc_addr[7:0] is decoded. Offset 0x00 is select, 0x10 is the data window and 0x40 is end-of-interrupt, so 0x100 aliases the select register.
- R3: The select register is written from acc_wdata[7:0] at offset 0x00 with any size. A read there returns {24'b0, select}.
- R4: A window access with acc_size other than 4 is ignored, and such a read returns zero.
- R5: Index 0x00 is the identification register. A write stores acc_wdata[27:24]. Reads of index 0x00 and index 0x02 both return the identification in bits 27:24 and zeros elsewhere. Writes to index 0x02 have no effect.
- R6: Index 0x01 reads as VERSION in bits 7:0 and NPINS-1 in bits 23:16, with zeros elsewhere. Writes to it have no effect.
- R7: A select value s >= 0x10 addresses entry (s-0x10)/2. An odd s reaches bits 63:32 and an even s reaches bits 31:0. An entry index >= NPINS, or a select below 0x10 other than 0x00..0x02, reads as zero and ignores writes.
- R8: Entry bits 12 (delivery status) and 14 (remote request) change only through the status inputs, never through a write. Bits 0-11, 13, 15, 16 and 56-63 are writable. Bits 17-55 always read zero.
- R9: An entry write that leaves bit 15 (trigger, 1 = level) at 0 clears bit 14.
- R10: A 4-byte write at offset 0x40 raises eoi_valid for one cycle with eoi_vector = acc_wdata[7:0], but only when VERSION is 0x20. Otherwise it does nothing.
- R11: Every accepted 4-byte window write to a valid entry raises ent_chg for one cycle, with ent_chg_idx set to that entry.
- R12: An access is accepted when acc_valid and acc_ready are both high. Its response (rd_valid, ent_chg or eoi_valid) appears in the next cycle, during which acc_ready is low. At most one response is active at a time, and rd_data is zero when rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access size in bytes |
| acc_addr | input | AW | Access offset |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Block can accept an access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| rirr_set | input | NPINS | Set remote-request bit per entry |
| rirr_clr | input | NPINS | Clear remote-request bit per entry |
| dlv_set | input | NPINS | Set delivery-status bit per entry |
| dlv_clr | input | NPINS | Clear delivery-status bit per entry |
| tbl_flat | output | NPINS*64 | Routing table, entry i at bits i*64 +: 64 |
| ent_chg | output | 1 | Entry changed pulse |
| ent_chg_idx | output | $clog2(NPINS) | Index of the changed entry |
| eoi_valid | output | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | output | 8 | Broadcast vector |

## Verification
An access accepted at a rising edge has its response due in the cycle that follows that edge. This covers read data, the entry-changed pulse, the broadcast strobe and the updated table contents. A status pulse applied before an edge shows in the table right after that edge. The bench keeps a behavioural model that advances at each rising edge with the inputs the design saw. Every output is compared at the next falling edge, so each result is checked in exactly the cycle it is due. Two instances, built as version 0x20 and version 0x11, receive the same stimulus so that the version gating of end-of-interrupt is observed side by side.

// File: rtl/irw_pkg.sv
package irw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_ENTRY,
        ST_EOI
    } irw_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_IDENT,
        K_VER,
        K_ARB,
        K_ENT
    } irw_kind_e;

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_WIN  = 8'h10;
    localparam logic [7:0] OFS_EOI  = 8'h40;

    localparam logic [7:0] IX_IDENT = 8'h00;
    localparam logic [7:0] IX_VER   = 8'h01;
    localparam logic [7:0] IX_ARB   = 8'h02;
    localparam logic [7:0] IX_TBL   = 8'h10;

    localparam int B_DLV  = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;
    localparam int B_MASK = 16;

    localparam logic [63:0] ENT_RW_MASK = 64'hFF00_0000_0001_AFFF;
    localparam logic [63:0] ENT_RO_MASK = 64'h0000_0000_0000_5000;
    localparam logic [63:0] ENT_RESET   = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDXW  = 5
) (
    input  logic [7:0]      ofs,
    input  logic [7:0]      sel,
    output logic            hit_sel,
    output logic            hit_win,
    output logic            hit_eoi,
    output irw_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic            hi
);

    logic [7:0] rel;
    logic [6:0] pair;

    assign rel     = sel - IX_TBL;
    assign pair    = rel[7:1];
    assign hit_sel = (ofs == OFS_SEL);
    assign hit_win = (ofs == OFS_WIN);
    assign hit_eoi = (ofs == OFS_EOI);
    assign idx     = pair[IDXW-1:0];
    assign hi      = sel[0];

    always_comb begin
        if (sel == IX_IDENT)                                kind = K_IDENT;
        else if (sel == IX_VER)                             kind = K_VER;
        else if (sel == IX_ARB)                             kind = K_ARB;
        else if (sel >= IX_TBL && 32'(pair) < NPINS)        kind = K_ENT;
        else                                                kind = K_NONE;
    end

endmodule

// File: rtl/irw_entry.sv
module irw_entry
    import irw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dlv_set,
    input  logic        dlv_clr,
    output logic [63:0] ent
);

    logic [63:0] ro_bits;
    logic [63:0] ent_d;

    always_comb begin
        ro_bits = ent & ENT_RO_MASK;
        if (dlv_set)  ro_bits[B_DLV]  = 1'b1;
        if (dlv_clr)  ro_bits[B_DLV]  = 1'b0;
        if (rirr_set) ro_bits[B_RIRR] = 1'b1;
        if (rirr_clr) ro_bits[B_RIRR] = 1'b0;

        ent_d = (ent & ~ENT_RO_MASK) | ro_bits;
        if (wr_lo) ent_d = ({ent[63:32], wdata} & ENT_RW_MASK) | ro_bits;
        if (wr_hi) ent_d = ({wdata, ent[31:0]} & ENT_RW_MASK) | ro_bits;
        if ((wr_lo || wr_hi) && !ent_d[B_TRIG]) ent_d[B_RIRR] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent <= ENT_RESET;
        else        ent <= ent_d;
    end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irw_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         AW      = 12,
    localparam int        IDXW    = $clog2(NPINS),
    localparam int        TBLW    = NPINS * 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [2:0]        acc_size,
    input  logic [AW-1:0]     acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic              acc_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  rirr_set,
    input  logic [NPINS-1:0]  rirr_clr,
    input  logic [NPINS-1:0]  dlv_set,
    input  logic [NPINS-1:0]  dlv_clr,
    output logic [TBLW-1:0]   tbl_flat,
    output logic              ent_chg,
    output logic [IDXW-1:0]   ent_chg_idx,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);

    localparam bit EOI_EN = (VERSION == 8'h20);

    irw_state_e       state_q, state_d;
    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [31:0]      rdata_q, rdata_d;
    logic [IDXW-1:0]  chg_idx_q;
    logic [7:0]       eoi_vec_q;

    logic             hit_sel, hit_win, hit_eoi, ent_hi;
    irw_kind_e        kind;
    logic [IDXW-1:0]  ent_idx;
    logic             accept, size4, ent_wr, eoi_wr;
    logic [63:0]      ent_arr [NPINS];
    logic [31:0]      unused_hi_bits;

    assign unused_hi_bits = {{(32-AW+8){1'b0}}, acc_addr[AW-1:8]};

    irw_decode #(.NPINS(NPINS), .IDXW(IDXW)) u_dec (
        .ofs     (acc_addr[7:0]),
        .sel     (sel_q),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .hit_eoi (hit_eoi),
        .kind    (kind),
        .idx     (ent_idx),
        .hi      (ent_hi)
    );

    assign accept = acc_valid && (state_q == ST_IDLE);
    assign size4  = (acc_size == 3'd4);
    assign ent_wr = accept && acc_write && hit_win && size4 && (kind == K_ENT);
    assign eoi_wr = accept && acc_write && hit_eoi && size4 && EOI_EN;

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        irw_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (ent_wr && ent_idx == IDXW'(i) && !ent_hi),
            .wr_hi    (ent_wr && ent_idx == IDXW'(i) &&  ent_hi),
            .wdata    (acc_wdata),
            .rirr_set (rirr_set[i]),
            .rirr_clr (rirr_clr[i]),
            .dlv_set  (dlv_set[i]),
            .dlv_clr  (dlv_clr[i]),
            .ent      (ent_arr[i])
        );
        assign tbl_flat[i*64 +: 64] = ent_arr[i];
    end

    // read value for the access presented this cycle
    always_comb begin
        rdata_d = 32'h0;
        if (hit_sel) begin
            rdata_d = {24'h0, sel_q};
        end else if (hit_win && size4) begin
            unique case (kind)
                K_IDENT, K_ARB: rdata_d = {4'h0, id_q, 24'h0};
                K_VER:          rdata_d = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
                K_ENT:          rdata_d = ent_hi ? ent_arr[ent_idx][63:32]
                                                 : ent_arr[ent_idx][31:0];
                default:        rdata_d = 32'h0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !acc_write) state_d = ST_READ;
                else if (ent_wr)          state_d = ST_ENTRY;
                else if (eoi_wr)          state_d = ST_EOI;
            end
            ST_READ, ST_ENTRY, ST_EOI: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_ready = 1'b0;
        rd_valid  = 1'b0;
        ent_chg   = 1'b0;
        eoi_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  acc_ready = 1'b1;
            ST_READ:  rd_valid  = 1'b1;
            ST_ENTRY: ent_chg   = 1'b1;
            ST_EOI:   eoi_valid = 1'b1;
            default:  acc_ready = 1'b0;
        endcase
    end

    assign rd_data     = rd_valid ? rdata_q : 32'h0;
    assign ent_chg_idx = chg_idx_q;
    assign eoi_vector  = eoi_vec_q;

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= 8'h00;
            id_q      <= 4'h0;
            rdata_q   <= 32'h0;
            chg_idx_q <= '0;
            eoi_vec_q <= 8'h00;
        end else begin
            if (accept && !acc_write) rdata_q <= rdata_d;
            if (accept && acc_write && hit_sel) sel_q <= acc_wdata[7:0];
            if (accept && acc_write && hit_win && size4 && kind == K_IDENT)
                id_q <= acc_wdata[27:24];
            if (ent_wr) chg_idx_q <= ent_idx;
            if (eoi_wr) eoi_vec_q <= acc_wdata[7:0];
        end
    end

endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         AW      = 12,
    localparam int        IDXW    = $clog2(NPINS),
    localparam int        TBLW    = NPINS * 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            acc_write,
    input logic [2:0]      acc_size,
    input logic [AW-1:0]   acc_addr,
    input logic            acc_ready,
    input logic            rd_valid,
    input logic            ent_chg,
    input logic [IDXW-1:0] ent_chg_idx,
    input logic            eoi_valid,
    input logic [TBLW-1:0] tbl_flat
);

    logic [63:0] chg_ent;
    logic        resv_any;

    assign chg_ent = tbl_flat[int'(ent_chg_idx) * 64 +: 64];

    always_comb begin
        resv_any = 1'b0;
        for (int i = 0; i < NPINS; i++) resv_any |= |tbl_flat[i*64 + 17 +: 39];
    end

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, ent_chg, eoi_valid}));                          // R12
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_ready |=> acc_ready);                                          // R12
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready && !acc_write) |=> rd_valid);              // R12
    AST_EDGE_NO_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        ent_chg |-> (chg_ent[15] || !chg_ent[14]));                         // R9
    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !resv_any);                                                         // R8
    AST_EOI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (VERSION == 8'h20));                                  // R10
    AST_EOI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(acc_valid && acc_write && acc_size == 3'd4
                            && acc_addr[7:0] == 8'h40));                    // R10

endmodule

bind irq_route_regfile irw_checker #(.NPINS(NPINS), .VERSION(VERSION), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_size    (acc_size),
    .acc_addr    (acc_addr),
    .acc_ready   (acc_ready),
    .rd_valid    (rd_valid),
    .ent_chg     (ent_chg),
    .ent_chg_idx (ent_chg_idx),
    .eoi_valid   (eoi_valid),
    .tbl_flat    (tbl_flat)
);

// File: tb/sim_irq_route_regfile.sv
`timescale 1ns/1ps
module sim_irq_route_regfile;

    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_valid = 1'b0, b_write = 1'b0;
    logic [2:0]  b_size = 3'd4;
    logic [11:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [NP-1:0] s_rset = '0, s_rclr = '0, s_dset = '0, s_dclr = '0;

    logic        rdy [2];
    logic        rv [2];
    logic [31:0] rdat [2];
    logic [NP*64-1:0] tbl [2];
    logic        chg [2];
    logic [4:0]  chgi [2];
    logic        eoi [2];
    logic [7:0]  eoiv [2];

    always #2.5 clk = ~clk;

    irq_route_regfile #(.NPINS(NP), .VERSION(8'h20)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_write),
        .acc_size(b_size), .acc_addr(b_addr), .acc_wdata(b_wdata),
        .acc_ready(rdy[0]), .rd_valid(rv[0]), .rd_data(rdat[0]),
        .rirr_set(s_rset), .rirr_clr(s_rclr), .dlv_set(s_dset), .dlv_clr(s_dclr),
        .tbl_flat(tbl[0]), .ent_chg(chg[0]), .ent_chg_idx(chgi[0]),
        .eoi_valid(eoi[0]), .eoi_vector(eoiv[0]));

    irq_route_regfile #(.NPINS(NP), .VERSION(8'h11)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_write),
        .acc_size(b_size), .acc_addr(b_addr), .acc_wdata(b_wdata),
        .acc_ready(rdy[1]), .rd_valid(rv[1]), .rd_data(rdat[1]),
        .rirr_set(s_rset), .rirr_clr(s_rclr), .dlv_set(s_dset), .dlv_clr(s_dclr),
        .tbl_flat(tbl[1]), .ent_chg(chg[1]), .ent_chg_idx(chgi[1]),
        .eoi_valid(eoi[1]), .eoi_vector(eoiv[1]));

    // behavioural reference
    logic [7:0]  m_sel [2];
    logic [3:0]  m_id [2];
    logic [63:0] m_tbl [2][NP];
    logic        m_rv [2], m_chg [2], m_eoi [2];
    logic [31:0] m_rdata [2];
    int          m_chgi [2];
    logic [7:0]  m_eoiv [2];
    logic [7:0]  m_ver [2];

    int    n_checks = 0, n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int v);
        int a, s, ix;
        a = int'(b_addr[7:0]);
        s = int'(m_sel[v]);
        if (a == 0) return {24'h0, m_sel[v]};
        if (a != 16 || b_size != 3'd4) return 32'h0;
        if (s == 0 || s == 2) return {4'h0, m_id[v], 24'h0};
        if (s == 1) return {8'h00, 8'(NP - 1), 8'h00, m_ver[v]};
        if (s < 16) return 32'h0;
        ix = (s - 16) / 2;
        if (ix >= NP) return 32'h0;
        return (s % 2 == 1) ? m_tbl[v][ix][63:32] : m_tbl[v][ix][31:0];
    endfunction

    task automatic m_reset();
        for (int v = 0; v < 2; v++) begin
            m_sel[v] = 0; m_id[v] = 0; m_rv[v] = 0; m_chg[v] = 0; m_eoi[v] = 0;
            m_rdata[v] = 0; m_chgi[v] = 0; m_eoiv[v] = 0;
            for (int i = 0; i < NP; i++) m_tbl[v][i] = 64'h1_0000;
        end
        m_ver[0] = 8'h20; m_ver[1] = 8'h11;
    endtask

    task automatic m_edge();
        for (int v = 0; v < 2; v++) begin
            bit busy, acc;
            int a, s, ix;
            logic [63:0] w;
            busy = m_rv[v] || m_chg[v] || m_eoi[v];
            acc  = b_valid && !busy;
            a = int'(b_addr[7:0]);
            s = int'(m_sel[v]);
            m_rv[v] = 0; m_chg[v] = 0; m_eoi[v] = 0;
            if (acc && !b_write) begin
                m_rv[v] = 1;
                m_rdata[v] = m_read(v);
            end
            for (int i = 0; i < NP; i++) begin
                if (s_dset[i]) m_tbl[v][i][12] = 1;
                if (s_dclr[i]) m_tbl[v][i][12] = 0;
                if (s_rset[i]) m_tbl[v][i][14] = 1;
                if (s_rclr[i]) m_tbl[v][i][14] = 0;
            end
            if (acc && b_write) begin
                if (a == 0) m_sel[v] = b_wdata[7:0];
                else if (a == 16 && b_size == 3'd4) begin
                    if (s == 0) m_id[v] = b_wdata[27:24];
                    else if (s >= 16 && (s - 16) / 2 < NP) begin
                        ix = (s - 16) / 2;
                        w = m_tbl[v][ix];
                        if (s % 2 == 1) w[63:32] = b_wdata; else w[31:0] = b_wdata;
                        w = (w & 64'hFF00_0000_0001_AFFF) | (m_tbl[v][ix] & 64'h5000);
                        if (!w[15]) w[14] = 0;
                        m_tbl[v][ix] = w;
                        m_chg[v] = 1; m_chgi[v] = ix;
                    end
                end else if (a == 64 && b_size == 3'd4 && m_ver[v] == 8'h20) begin
                    m_eoi[v] = 1; m_eoiv[v] = b_wdata[7:0];
                end
            end
        end
    endtask

    task automatic compare();
        for (int v = 0; v < 2; v++) begin
            chk(rdy[v] == !(m_rv[v] || m_chg[v] || m_eoi[v]), "R12", "acc_ready",
                64'(rdy[v]), 64'(!(m_rv[v] || m_chg[v] || m_eoi[v])));
            chk(rv[v] == m_rv[v], "R12", "rd_valid", 64'(rv[v]), 64'(m_rv[v]));
            chk(rdat[v] == (m_rv[v] ? m_rdata[v] : 32'h0), cur_req, "rd_data",
                64'(rdat[v]), 64'(m_rv[v] ? m_rdata[v] : 32'h0));
            chk(chg[v] == m_chg[v], "R11", "ent_chg", 64'(chg[v]), 64'(m_chg[v]));
            if (m_chg[v])
                chk(int'(chgi[v]) == m_chgi[v], "R11", "ent_chg_idx",
                    64'(chgi[v]), 64'(m_chgi[v]));
            chk(eoi[v] == m_eoi[v], "R10", "eoi_valid", 64'(eoi[v]), 64'(m_eoi[v]));
            if (m_eoi[v])
                chk(eoiv[v] == m_eoiv[v], "R10", "eoi_vector", 64'(eoiv[v]), 64'(m_eoiv[v]));
            for (int i = 0; i < NP; i++)
                chk(tbl[v][i*64 +: 64] == m_tbl[v][i], cur_req, $sformatf("entry %0d", i),
                    tbl[v][i*64 +: 64], m_tbl[v][i]);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic acc(input bit wr, input int sz, input int ad, input logic [31:0] d);
        b_valid = 1; b_write = wr; b_size = 3'(sz); b_addr = 12'(ad); b_wdata = d;
        step();
        b_valid = 0;
        step();
    endtask

    task automatic status(input int ix, input bit rs, input bit rc, input bit ds, input bit dc);
        s_rset[ix] = rs; s_rclr[ix] = rc; s_dset[ix] = ds; s_dclr[ix] = dc;
        step();
        s_rset = '0; s_rclr = '0; s_dset = '0; s_dclr = '0;
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        compare();
        step();

        cur_req = "R3";
        acc(1, 4, 'h000, 32'hFFFF_FF15);
        acc(0, 4, 'h000, 0);
        acc(1, 1, 'h000, 32'h0000_0002);
        acc(0, 2, 'h000, 0);

        cur_req = "R2";
        acc(1, 4, 'h200, 32'h0000_0001);
        acc(0, 4, 'h100, 0);
        acc(0, 4, 'hF10, 0);

        cur_req = "R5";
        acc(1, 4, 'h000, 0);
        acc(1, 4, 'h010, 32'hFFFF_FFFF);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h000, 2);
        acc(1, 4, 'h010, 32'h0300_0000);
        acc(0, 4, 'h010, 0);

        cur_req = "R6";
        acc(1, 4, 'h000, 1);
        acc(1, 4, 'h010, 32'h0000_0000);
        acc(0, 4, 'h010, 0);

        cur_req = "R4";
        acc(0, 2, 'h010, 0);
        acc(1, 4, 'h000, 0);
        acc(1, 1, 'h010, 32'h0700_0000);
        acc(0, 4, 'h010, 0);

        cur_req = "R7";
        acc(1, 4, 'h000, 'h10);
        acc(1, 4, 'h010, 32'h0000_8931);
        acc(1, 4, 'h000, 'h11);
        acc(1, 4, 'h010, 32'hAB12_3456);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h000, 'h10);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h000, 'h3F);
        acc(1, 4, 'h010, 32'hC000_0000);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h000, 'h40);
        acc(1, 4, 'h010, 32'hFFFF_FFFF);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h000, 'h05);
        acc(0, 4, 'h010, 0);

        cur_req = "R8";
        acc(1, 4, 'h000, 'h16);
        acc(1, 4, 'h010, 32'h0000_8040);
        status(3, 1, 0, 1, 0);
        acc(1, 4, 'h010, 32'hFFFF_AFFF);
        acc(0, 4, 'h010, 0);
        acc(1, 4, 'h010, 32'h0000_8000);
        status(3, 0, 0, 0, 1);
        acc(1, 4, 'h000, 'h17);
        acc(1, 4, 'h010, 32'hFFFF_FFFF);
        acc(0, 4, 'h010, 0);

        cur_req = "R9";
        acc(1, 4, 'h000, 'h16);
        acc(1, 4, 'h010, 32'h0001_0022);
        acc(0, 4, 'h010, 0);
        status(3, 1, 0, 0, 0);
        acc(1, 4, 'h010, 32'h0000_8022);

        cur_req = "R10";
        acc(1, 4, 'h040, 32'hFFFF_FF5A);
        acc(1, 2, 'h040, 32'h0000_0033);
        acc(1, 4, 'h140, 32'h0000_00C7);

        cur_req = "R12";
        b_valid = 1; b_write = 0; b_size = 4; b_addr = 'h010; b_wdata = 0;
        repeat (4) step();
        b_valid = 1; b_write = 1; b_addr = 'h010; b_wdata = 32'h0000_0077;
        repeat (3) step();
        b_valid = 0;
        step();

        cur_req = "R11";
        acc(1, 4, 'h000, 'h2E);
        acc(1, 4, 'h010, 32'h0000_00EE);
        step();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule